// File: doc/BRIEF.md
# RAM-Backed Tapped Delay Line

This block delays a stream of `W`-bit samples through `N` equally spaced taps, with `M` samples between neighbouring taps. The history is not held in a chain of flip-flops. It is held in `N` small memories of `M` words each, all addressed by one shared circular pointer. Every accepted sample moves the whole line by one position within a single clock period. The current word at the pointer is read on the rising edge, and the replacement word is written back on the falling edge of the same cycle. All tap values are presented side by side on one wide bus, so a filter or correlator next to the block can use them in place.

Samples enter through a valid/ready port. After reset the block spends exactly `M` cycles sweeping zeros into every memory word. During that sweep `in_ready` is low, and any valid sample is refused. Once the sweep ends, `in_ready` stays high until the next reset, so the producer sees back-pressure only during the sweep. A sample is taken on every rising edge where `in_valid` and `in_ready` are both high. Idle cycles freeze the line. The output side has no handshake. `tap_valid` marks the cycle in which `tap_bus` shows a freshly shifted set of taps, and the bus holds its value at all other times.

The parameters are bounded at elaboration. Total storage `W*M*N` may not exceed 4608 bits, and the bus width `W*N` may not exceed 36 bits.

Top module: `tapped_delay_ram`

## Requirements
- R1: After reset is released, `in_ready` stays low for exactly `M` rising edges (the zero sweep) and then goes high.
- R2: While `in_ready` is low, a high `in_valid` is refused. `tap_valid` stays low, and the refused sample never appears on any tap.
- R3: After the s-th accepted sample, tap k (k = 1..N) holds accepted sample number s − k·M. When s ≤ k·M, tap k holds zero.
- R4: Tap k occupies `tap_bus` bits [k·W−1 : (k−1)·W], so tap 1 sits in the least significant `W` bits.
- R5: `tap_valid` is high for exactly the one cycle after each accepting edge, and `tap_bus` changes only at accepting edges.
- R6: Cycles with `in_valid` low neither advance the line nor alter any tap, so tap contents depend only on the order of accepted samples.
- R7: Asserting `rst_n` low at any time forces `tap_bus` to zero and `in_ready` low. The following sweep erases all earlier history.
- R8: Once `in_ready` has gone high, it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; reads on the rising edge, memory writes on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset; starts the zero sweep |
| in_valid | input | 1 | Producer has a sample on `in_data` |
| in_ready | output | 1 | Block can take a sample (low only during the sweep) |
| in_data | input | W | Incoming sample |
| tap_valid | output | 1 | `tap_bus` was updated at the last rising edge |
| tap_bus | output | W*N | All tap values; tap 1 in the lowest `W` bits |

## Verification
The assertions watch the handshake and timing rules on every cycle. They check that the sweep lasts exactly `M` edges, that ready never falls back once raised, that nothing is taken while ready is low, and that the tap bus is frozen whenever `tap_valid` is low. The numeric content of each tap can only be shown by the bench's scenarios. These compare every tap, after every step, with a queue of accepted samples under continuous input, random gaps in `in_valid`, refused samples during the sweep, and a reset in the middle of a stream that must leave no stale history behind.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int unsigned STORE_LIMIT_BITS = 4608;
  localparam int unsigned BUS_LIMIT_BITS   = 36;

  typedef enum logic {
    ST_SWEEP = 1'b0,
    ST_RUN   = 1'b1
  } seq_state_t;
endpackage

// File: rtl/tdr_seq.sv
module tdr_seq
  import tdr_pkg::*;
#(
  parameter int M  = 5,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          shift,
  output logic          sweep,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(M - 1);

  seq_state_t    state_q;
  logic [AW-1:0] addr_q;
  logic          at_last;

  assign at_last  = (addr_q == LAST);
  assign sweep    = (state_q == ST_SWEEP);
  assign in_ready = (state_q == ST_RUN);
  assign shift    = in_ready & in_valid;
  assign addr     = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SWEEP;
      addr_q  <= '0;
    end else begin
      case (state_q)
        ST_SWEEP: begin
          addr_q <= at_last ? '0 : addr_q + 1'b1;
          if (at_last) state_q <= ST_RUN;
        end
        default: begin
          if (shift) addr_q <= at_last ? '0 : addr_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/tdr_bank.sv
module tdr_bank #(
  parameter int W  = 8,
  parameter int M  = 5,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic          sweep,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  rd_now,
  output logic [W-1:0]  dout
);
  logic [W-1:0]  mem [0:M-1];
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_val;

  assign rd_now = mem[addr];

  // rising edge: take the outgoing word and stage the incoming one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_val  <= '0;
      dout    <= '0;
    end else begin
      wr_en   <= shift | sweep;
      wr_addr <= addr;
      wr_val  <= sweep ? '0 : din;
      if (shift) dout <= rd_now;
    end
  end

  // falling edge: commit the staged word into the same slot
  always_ff @(negedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_val;
  end
endmodule

// File: rtl/tapped_delay_ram.sv
module tapped_delay_ram
  import tdr_pkg::*;
#(
  parameter int W = 8,
  parameter int M = 5,
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  output logic           tap_valid,
  output logic [W*N-1:0] tap_bus
);
  localparam int AW = (M > 1) ? $clog2(M) : 1;

  if (W * M * N > int'(STORE_LIMIT_BITS)) begin : g_store_too_big
    $error("tapped_delay_ram: W*M*N exceeds storage limit");
  end
  if (W * N > int'(BUS_LIMIT_BITS)) begin : g_bus_too_wide
    $error("tapped_delay_ram: W*N exceeds tap bus limit");
  end

  logic          shift;
  logic          sweep;
  logic [AW-1:0] addr;
  logic [W-1:0]  din    [N];
  logic [W-1:0]  rd_now [N];
  logic [W-1:0]  dout   [N];

  tdr_seq #(.M(M), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .shift    (shift),
    .sweep    (sweep),
    .addr     (addr)
  );

  for (genvar k = 0; k < N; k++) begin : g_tap
    if (k == 0) begin : g_head
      assign din[k] = in_data;
    end else begin : g_chain
      assign din[k] = rd_now[k-1];
    end

    tdr_bank #(.W(W), .M(M), .AW(AW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .shift  (shift),
      .sweep  (sweep),
      .addr   (addr),
      .din    (din[k]),
      .rd_now (rd_now[k]),
      .dout   (dout[k])
    );

    assign tap_bus[k*W +: W] = dout[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_valid <= 1'b0;
    else        tap_valid <= shift;
  end
endmodule

// File: rtl/tdr_chk.sv
module tdr_chk #(
  parameter int W = 8,
  parameter int M = 5,
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           tap_valid,
  input logic [W*N-1:0] tap_bus
);
  int unsigned sweep_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sweep_cnt <= 0;
    else if (!in_ready) sweep_cnt <= sweep_cnt + 1;
  end

  assert_sweep_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> sweep_cnt == M);

  assert_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> !tap_valid);

  assert_valid_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tap_valid |-> $past(in_valid && in_ready));

  assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_valid |-> $stable(tap_bus));

  assert_ready_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
endmodule

bind tapped_delay_ram tdr_chk #(.W(W), .M(M), .N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .tap_valid (tap_valid),
  .tap_bus   (tap_bus)
);

// File: tb/tapped_delay_ram_tb.sv
module tapped_delay_ram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int M = 5;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [W-1:0]   in_data = '0;
  logic           in_ready;
  logic           tap_valid;
  logic [W*N-1:0] tap_bus;

  int total = 0;
  int bad = 0;
  int unsigned hist [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tapped_delay_ram #(.W(W), .M(M), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tap_valid(tap_valid), .tap_bus(tap_bus)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_tap(input int k);
    int idx;
    idx = hist.size() - k * M;
    if (idx >= 1) return W'(hist[idx-1]);
    return '0;
  endfunction

  task automatic check_taps(input string tag);
    for (int k = 1; k <= N; k++) begin
      logic [W-1:0] got;
      got = tap_bus[(k-1)*W +: W];
      chk(got == exp_tap(k), $sformatf("%s R3 R4 tap%0d", tag, k), 64'(got), 64'(exp_tap(k)));
    end
  endtask

  task automatic push(input bit v, input logic [W-1:0] d, input string tag);
    bit rdy;
    bit acc;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    rdy = in_ready;
    @(posedge clk);
    #1;
    acc = v && rdy;
    if (acc) hist.push_back(int'(d));
    chk(tap_valid == acc, {tag, " R5 tap_valid"}, 64'(tap_valid), 64'(acc));
    check_taps(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(tap_bus == '0, {tag, " R7 bus zero in reset"}, 64'(tap_bus), 64'd0);
    chk(in_ready == 1'b0, {tag, " R7 ready low in reset"}, 64'(in_ready), 64'd0);
    chk(tap_valid == 1'b0, {tag, " R7 tap_valid low in reset"}, 64'(tap_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    hist.delete();
  endtask

  // R1, R2: sweep length and refusal of offered samples during it
  task automatic t_sweep_window();
    int n = 0;
    in_valid = 1'b1;
    in_data  = 8'hA5;
    do begin
      @(posedge clk);
      #1;
      n++;
      chk(tap_valid == 1'b0, "R2 no take during sweep", 64'(tap_valid), 64'd0);
    end while (!in_ready && n < 4 * M);
    chk(n == M, "R1 sweep length", 64'(n), 64'(M));
    @(negedge clk);
    in_valid = 1'b0;
    check_taps("R2 refused sample absent");
  endtask

  // R3, R4, R5: back-to-back samples through every tap
  task automatic t_ramp();
    for (int i = 0; i < M * N + 4; i++) push(1'b1, W'(8'h10 + i), "ramp");
  endtask

  // R6, R8: random gaps in in_valid
  task automatic t_gaps();
    for (int i = 0; i < 80; i++) begin
      push(1'($urandom_range(0, 1)), W'($urandom), "R6 gaps");
      chk(in_ready == 1'b1, "R8 ready stays high", 64'(in_ready), 64'd1);
    end
  endtask

  // R7: reset mid-stream wipes history
  task automatic t_midreset();
    for (int i = 0; i < 7; i++) push(1'b1, W'(8'hC0 + i), "pre-reset");
    do_reset("midstream");
    while (!in_ready) begin
      @(posedge clk);
      #1;
    end
    for (int i = 0; i < M * N + 2; i++) push(1'b1, W'(8'h40 + i), "R7 after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(tap_bus == '0, "R7 reset state bus", 64'(tap_bus), 64'd0);
    chk(in_ready == 1'b0, "R7 reset state ready", 64'(in_ready), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    t_sweep_window();
    t_ramp();
    t_gaps();
    t_midreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule